// File: doc/BRIEF.md
# Serial Byte-Stream Memory Loader

This block lets an external host fill or dump a code memory over a byte-wide link. The block waits idle until the enable input `boot_en` is high. It then takes a five-byte header from a valid/ready input stream, in this order: an operation byte, a byte count, the high address byte, the low address byte and a type tag. Write operations store the payload bytes that follow into memory at consecutive addresses. Read operations fetch the same number of bytes from memory and return them on a valid/ready output stream.

Every transfer that reaches the payload phase ends with one checksum byte. That byte is the two's-complement negation of the 8-bit sum of the header and the payload. When a host adds every byte it sent or received, including this trailing byte, the result is zero modulo 256.

Back-pressure rules: a byte moves on either stream only in a cycle where valid and ready are both high. The source may hold valid high for any number of cycles. While `out_valid` is high and `out_ready` is low, the block keeps `out_valid` high and `out_data` unchanged. `in_ready` is high only while the block is able to consume a byte. The memory port is synchronous: read data appears one cycle after `mem_re`.

Top module: `stream_mem_loader`

## Requirements
- R1: After reset `in_ready`, `out_valid`, `mem_we` and `mem_re` are low. The block leaves idle only when `boot_en` is high, and `in_ready` rises in the cycle after `boot_en` is seen.
- R2: Header bytes are taken only on an input handshake, in this order: operation, count, address[15:7+1], address[7:0], type tag.
- R3: The trailing byte equals the negation modulo 256 of the sum of the five header bytes and all payload bytes. The checksum starts from zero for each transfer.
- R4: Operation 8'h01 with type tag 8'h00 writes each accepted payload byte to memory. `mem_we` is high in the handshake cycle only, with `mem_wdata` equal to the byte, and the addresses run upward from the header address.
- R5: Operation 8'h02 with type tag 8'h00 sends count bytes read from consecutive addresses starting at the header address, in address order. The next byte is fetched only after the previous one has left.
- R6: Any operation byte other than 8'h01 or 8'h02 returns the block to idle after the header. No memory access and no output byte follow.
- R7: A type tag other than 8'h00 returns the block to idle after the header, for both operations, with no memory access and no output byte.
- R8: A count of zero skips the payload phase. The only output byte is the checksum of the header.
- R9: The address wraps from 16'hFFFF to 16'h0000 within one transfer.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable in the next cycle.
- R11: `in_ready` is low in idle and during output phases, and input bytes offered then have no effect. Between transfers, with `boot_en` low, the block rests in idle with `in_ready` low.
- R12: `mem_rdata` is sampled in the cycle after `mem_re`, and the fetched byte is offered on the output one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_en | input | 1 | Allows a new transfer to start from idle |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output byte (read data or checksum) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_re` |

## Verification
The hardest case to reach from the ports is a read payload that is stalled by the sink in the middle of a transfer while its address range crosses 16'hFFFF. In that case the stall, the address wrap and the per-byte fetch all interact. The stimulus presets the memory model and issues a write header with address 16'hFFFE, then a read header with the same address. For the read, `out_ready` is driven by a throttled pattern that accepts one cycle in four, so each byte is held for several cycles before it moves. Rejected operations and tags are followed by a window in which nothing may be written or sent, and that window is watched.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OP,
    ST_CNT,
    ST_AHI,
    ST_ALO,
    ST_TAG,
    ST_ROUTE,
    ST_WR,
    ST_RD_REQ,
    ST_RD_CAP,
    ST_RD_SEND,
    ST_CK_NEG,
    ST_CK_SEND
  } ldr_state_e;

  typedef struct packed {
    logic clr;
    logic ld_op;
    logic ld_cnt;
    logic ld_ahi;
    logic ld_alo;
    logic ld_tag;
    logic step;
    logic add_in;
    logic add_mem;
    logic negate;
    logic cap_rd;
  } ldr_ctl_t;

endpackage

// File: rtl/ldr_ctrl.sv
module ldr_ctrl
  import ldr_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter logic [DATA_W-1:0] OP_WR  = 'h01,
  parameter logic [DATA_W-1:0] OP_RD  = 'h02,
  parameter logic [DATA_W-1:0] TAG_DATA = 'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_en,
  input  logic              in_valid,
  input  logic              out_ready,
  input  logic [DATA_W-1:0] op_q,
  input  logic [DATA_W-1:0] tag_q,
  input  logic              cnt_zero,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_sel_ck,
  output logic              mem_we,
  output logic              mem_re,
  output ldr_ctl_t          ctl
);

  ldr_state_e state_q, state_d;
  logic       in_hs;
  logic       tag_ok;

  assign in_hs  = in_valid && in_ready;
  assign tag_ok = (tag_q == TAG_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    ctl        = '0;
    in_ready   = 1'b0;
    out_valid  = 1'b0;
    out_sel_ck = 1'b0;
    mem_we     = 1'b0;
    mem_re     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (boot_en) begin
          ctl.clr = 1'b1;
          state_d = ST_OP;
        end
      end
      ST_OP: begin
        in_ready = 1'b1;
        if (in_hs) begin
          ctl.ld_op  = 1'b1;
          ctl.add_in = 1'b1;
          state_d    = ST_CNT;
        end
      end
      ST_CNT: begin
        in_ready = 1'b1;
        if (in_hs) begin
          ctl.ld_cnt = 1'b1;
          ctl.add_in = 1'b1;
          state_d    = ST_AHI;
        end
      end
      ST_AHI: begin
        in_ready = 1'b1;
        if (in_hs) begin
          ctl.ld_ahi = 1'b1;
          ctl.add_in = 1'b1;
          state_d    = ST_ALO;
        end
      end
      ST_ALO: begin
        in_ready = 1'b1;
        if (in_hs) begin
          ctl.ld_alo = 1'b1;
          ctl.add_in = 1'b1;
          state_d    = ST_TAG;
        end
      end
      ST_TAG: begin
        in_ready = 1'b1;
        if (in_hs) begin
          ctl.ld_tag = 1'b1;
          ctl.add_in = 1'b1;
          state_d    = ST_ROUTE;
        end
      end
      ST_ROUTE: begin
        if (op_q == OP_WR && tag_ok)      state_d = ST_WR;
        else if (op_q == OP_RD && tag_ok) state_d = cnt_zero ? ST_CK_NEG : ST_RD_REQ;
        else                              state_d = ST_IDLE;
      end
      ST_WR: begin
        if (cnt_zero) begin
          state_d = ST_CK_NEG;
        end else begin
          in_ready = 1'b1;
          if (in_hs) begin
            mem_we     = 1'b1;
            ctl.step   = 1'b1;
            ctl.add_in = 1'b1;
          end
        end
      end
      ST_RD_REQ: begin
        mem_re  = 1'b1;
        state_d = ST_RD_CAP;
      end
      ST_RD_CAP: begin
        ctl.cap_rd  = 1'b1;
        ctl.add_mem = 1'b1;
        ctl.step    = 1'b1;
        state_d     = ST_RD_SEND;
      end
      ST_RD_SEND: begin
        out_valid = 1'b1;
        if (out_ready) state_d = cnt_zero ? ST_CK_NEG : ST_RD_REQ;
      end
      ST_CK_NEG: begin
        ctl.negate = 1'b1;
        state_d    = ST_CK_SEND;
      end
      ST_CK_SEND: begin
        out_valid  = 1'b1;
        out_sel_ck = 1'b1;
        if (out_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/ldr_datapath.sv
module ldr_datapath
  import ldr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ldr_ctl_t          ctl,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] op_q,
  output logic [DATA_W-1:0] tag_q,
  output logic              cnt_zero,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] rd_buf_q
);

  logic [DATA_W-1:0] cnt_q;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q     <= '0;
      tag_q    <= '0;
      cnt_q    <= '0;
      addr_q   <= '0;
      rd_buf_q <= '0;
    end else begin
      if (ctl.ld_op)  op_q  <= in_data;
      if (ctl.ld_tag) tag_q <= in_data;
      if (ctl.ld_cnt) cnt_q <= in_data;
      else if (ctl.step) cnt_q <= cnt_q - 1'b1;
      if (ctl.ld_ahi)      addr_q[ADDR_W-1:DATA_W] <= in_data;
      else if (ctl.ld_alo) addr_q[DATA_W-1:0]      <= in_data;
      else if (ctl.step)   addr_q                  <= addr_q + 1'b1;
      if (ctl.cap_rd) rd_buf_q <= mem_rdata;
    end
  end

endmodule

// File: rtl/ldr_cksum.sv
module ldr_cksum
  import ldr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ldr_ctl_t          ctl,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] sum_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)           sum_q <= '0;
    else if (ctl.clr)     sum_q <= '0;
    else if (ctl.add_in)  sum_q <= sum_q + in_data;
    else if (ctl.add_mem) sum_q <= sum_q + mem_rdata;
    else if (ctl.negate)  sum_q <= ~sum_q + 1'b1;
  end

endmodule

// File: rtl/stream_mem_loader.sv
module stream_mem_loader
  import ldr_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] OP_WR    = 'h01,
  parameter logic [DATA_W-1:0] OP_RD    = 'h02,
  parameter logic [DATA_W-1:0] TAG_DATA = 'h00,
  localparam int               ADDR_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata
);

  ldr_ctl_t          ctl;
  logic [DATA_W-1:0] op_q, tag_q, rd_buf_q, sum_q;
  logic              cnt_zero, out_sel_ck;

  ldr_ctrl #(
    .DATA_W(DATA_W), .OP_WR(OP_WR), .OP_RD(OP_RD), .TAG_DATA(TAG_DATA)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .in_valid(in_valid),
    .out_ready(out_ready), .op_q(op_q), .tag_q(tag_q), .cnt_zero(cnt_zero),
    .in_ready(in_ready), .out_valid(out_valid), .out_sel_ck(out_sel_ck),
    .mem_we(mem_we), .mem_re(mem_re), .ctl(ctl)
  );

  ldr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .in_data(in_data),
    .mem_rdata(mem_rdata), .op_q(op_q), .tag_q(tag_q), .cnt_zero(cnt_zero),
    .addr_q(mem_addr), .rd_buf_q(rd_buf_q)
  );

  ldr_cksum #(.DATA_W(DATA_W)) u_ck (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .in_data(in_data),
    .mem_rdata(mem_rdata), .sum_q(sum_q)
  );

  assign mem_wdata = in_data;
  assign out_data  = out_sel_ck ? sum_q : rd_buf_q;

endmodule

// File: rtl/stream_mem_loader_chk.sv
module stream_mem_loader_chk #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re
);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R4
  wr_on_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> in_valid && in_ready);

  // R9
  wr_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) + 1'b1);

  // R12
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re && !out_valid ##1 out_valid);

  // R11
  no_in_while_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready && !mem_we);

endmodule

bind stream_mem_loader stream_mem_loader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/stream_mem_loader_bench.sv
`timescale 1ns/1ps
module stream_mem_loader_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, mem_we, mem_re;
  logic [7:0]  out_data, mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] mem_addr;

  logic [7:0]  mem [0:255];
  logic [7:0]  out_q [$];
  logic [23:0] wr_q [$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          bp_mode = 1'b0;
  logic [1:0]  bp_cnt = '0;

  always #10 clk = ~clk;

  stream_mem_loader u_stream_mem_loader (
    .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata)
  );

  // synchronous memory model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  always begin
    @(posedge clk);
    #1;
    bp_cnt = bp_cnt + 1'b1;
    out_ready = bp_mode ? (bp_cnt == 2'b11) : 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (out_q.size() == 0) check("R6 R7 unexpected output byte", {24'h0, out_data}, 32'hFFFF_FFFF);
      else check("R3 R5 output byte", {24'h0, out_data}, {24'h0, out_q.pop_front()});
    end
    if (rst_n && mem_we) begin
      if (wr_q.size() == 0) check("R6 R7 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'hFFFF_FFFF);
      else check("R4 R9 write addr/data", {8'h0, mem_addr, mem_wdata}, {8'h0, wr_q.pop_front()});
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_data  = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_header(input logic [7:0] op, input logic [7:0] cnt,
                             input logic [15:0] a, input logic [7:0] tag);
    boot_en = 1'b1;
    send_byte(op);
    boot_en = 1'b0;
    send_byte(cnt);
    send_byte(a[15:8]);
    send_byte(a[7:0]);
    send_byte(tag);
  endtask

  task automatic wait_done();
    wait (out_q.size() == 0 && wr_q.size() == 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 idle after transfer", {31'h0, in_ready}, 32'h0);
  endtask

  task automatic run_write(input logic [15:0] a, input int n, input logic [7:0] seed);
    logic [7:0] s;
    s = 8'h01 + 8'(n) + a[15:8] + a[7:0] + 8'h00;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = seed + 8'(i * 37);
      s = s + d;
      wr_q.push_back({a + 16'(i), d});
    end
    out_q.push_back(-s);
    send_header(8'h01, 8'(n), a, 8'h00);
    for (int i = 0; i < n; i++) send_byte(seed + 8'(i * 37));
    wait_done();
  endtask

  task automatic run_read(input logic [15:0] a, input int n);
    logic [7:0] s;
    s = 8'h02 + 8'(n) + a[15:8] + a[7:0];
    for (int i = 0; i < n; i++) begin
      logic [15:0] ai;
      ai = a + 16'(i);
      s = s + mem[ai[7:0]];
      out_q.push_back(mem[ai[7:0]]);
    end
    out_q.push_back(-s);
    send_header(8'h02, 8'(n), a, 8'h00);
    wait_done();
  endtask

  task automatic run_reject(input logic [7:0] op, input logic [7:0] tag, input string req);
    send_header(op, 8'h03, 16'h0040, tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(req, {30'h0, in_ready, out_valid}, 32'h0);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5A);
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset outputs", {28'h0, in_ready, out_valid, mem_we, mem_re}, 32'h0);
        // R11 bytes offered while idle are ignored
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = 8'hEE;
        for (int i = 0; i < 5; i++) begin
          @(negedge clk);
          check("R11 ignore while idle", {31'h0, in_ready}, 32'h0);
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        // R1 start timing
        boot_en = 1'b1;
        @(negedge clk);
        check("R1 in_ready not yet", {31'h0, in_ready}, 32'h0);
        @(negedge clk);
        check("R1 in_ready after boot_en", {31'h0, in_ready}, 32'h1);
        boot_en = 1'b0;
        // header already started: finish a write of two bytes, R2 R3 R4
        wr_q.push_back({16'h0010, 8'hA1});
        wr_q.push_back({16'h0011, 8'hB2});
        out_q.push_back(-(8'h01 + 8'h02 + 8'h00 + 8'h10 + 8'h00 + 8'hA1 + 8'hB2));
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h00);
        send_byte(8'h10); send_byte(8'h00);
        send_byte(8'hA1); send_byte(8'hB2);
        wait_done();
        // R4 longer write, then R5 R12 read back with back-pressure R10
        run_write(16'h0020, 5, 8'h33);
        bp_mode = 1'b1;
        run_read(16'h0020, 5);
        run_read(16'h0010, 2);
        bp_mode = 1'b0;
        // R8 zero count on both operations
        run_write(16'h0050, 0, 8'h00);
        run_read(16'h0050, 0);
        // R6 bad operation, R7 bad tag
        run_reject(8'h07, 8'h00, "R6 reject op");
        run_reject(8'h01, 8'h05, "R7 reject tag write");
        run_reject(8'h02, 8'h09, "R7 reject tag read");
        // R9 wrap across 16'hFFFF
        run_write(16'hFFFE, 4, 8'hC4);
        bp_mode = 1'b1;
        run_read(16'hFFFE, 4);
        bp_mode = 1'b0;
        // R3 checksum restarts after rejected headers
        run_read(16'h0003, 1);
      end
      begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R3 watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule